// File: doc/BRIEF.md
# Two-bit ripple arithmetic slice

A 2-bit arithmetic cell meant to be tiled into wider datapaths. A three-bit operation code picks what the cell does: add, subtract, add or subtract chosen at run time by a separate control pin, count up, count down, count in a direction chosen by a pin, or compare A with B. The carry input and carry output link neighbouring slices into a ripple chain. The cell also puts out a group generate and a group propagate term for the 2-bit group, so a lookahead unit can skip over the ripple path.

Every arithmetic result is combinational, so a chain of slices settles within one cycle. The counter is different. Its value sits in a 2-bit register with an asynchronous clear and a synchronous preload, and in a counting mode the carry input acts as the count enable, so a chain of slices forms a wider counter. For subtraction and comparison the B operand is inverted, and the least significant slice of a chain must be driven with carry-in = 1. Its carry-out then means "no borrow", which is the same as "A >= B".

Top module: `arith_slice2`

## Requirements
- R1: With op = 0 (add), or with the unused code op = 7, res equals the low 2 bits of a + b + cin, and cout equals the carry out of that sum.
- R2: With op = 1 (subtract), res and cout are the low 2 bits and the carry of a + (~b) + cin. With cin = 1, res is a - b modulo 4 and cout = 1 exactly when no borrow occurred.
- R3: With op = 2, sub_sel = 1 gives the R2 behaviour and sub_sel = 0 gives the R1 behaviour.
- R4: In the non-counting modes, grp_g = g1 | (p1 & g0) and grp_p = p1 & p0, where gi = a[i] & x[i], pi = a[i] ^ x[i], and x is the B operand after any inversion. cout then equals grp_g | (grp_p & cin). In the counting modes both grp_g and grp_p are 0.
- R5: With op = 3 (count up), res shows the counter value. A clock edge with cin = 1 adds 1 modulo 4. cout = cin & (counter == 3).
- R6: With op = 4 (count down), a clock edge with cin = 1 subtracts 1 modulo 4. cout = cin & (counter == 0).
- R7: With op = 5, dir_up = 1 gives the R5 behaviour and dir_up = 0 gives the R6 behaviour, both for the counter update and for cout.
- R8: A clock edge with load = 0 leaves the counter unchanged if cin = 0 or if op is not a counting code (3, 4, 5).
- R9: A clock edge with load = 1 copies a into the counter in every mode, and this takes priority over counting.
- R10: aclr = 1 clears the counter to 0 at once, without waiting for a clock edge, and holds it at 0 while asserted, even with load = 1.
- R11: In every mode, ge = (a >= b), le = (a <= b) and ne = (a != b), with a and b taken as unsigned.
- R12: With op = 6 (compare), res and cout follow a + (~b) + cin. With cin = 1, cout = (a >= b).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the counter register |
| aclr | input | 1 | Asynchronous clear of the counter, active high |
| op | input | 3 | Operation code (0 add, 1 sub, 2 add/sub, 3 up, 4 down, 5 up/down, 6 compare, 7 add) |
| sub_sel | input | 1 | In op 2: 1 selects subtract, 0 selects add |
| dir_up | input | 1 | In op 5: 1 counts up, 0 counts down |
| load | input | 1 | Synchronous preload of the counter from a |
| cin | input | 1 | Carry input from the lower slice; acts as count enable in the counting modes |
| a | input | 2 | Operand A, also the preload value |
| b | input | 2 | Operand B |
| res | output | 2 | Sum or difference, or the counter value in the counting modes |
| cout | output | 1 | Carry output to the next slice |
| grp_g | output | 1 | Group carry-generate for the 2-bit group |
| grp_p | output | 1 | Group carry-propagate for the 2-bit group |
| ge | output | 1 | A greater than or equal to B |
| ne | output | 1 | A not equal to B |
| le | output | 1 | A less than or equal to B |

## Verification
The sum, carry, group terms and comparator flags have no register in their path, so they are due in the same cycle as their inputs. The bench drives inputs on the falling edge and samples them a short delay later. The counter value changes only on a rising edge, so the bench's model applies a load or a count step after that edge and compares against the next sample. The asynchronous clear is checked a short delay after aclr rises, well before any clock edge, to show it does not wait for the clock.

// File: rtl/arith_slice2_pkg.sv
package arith_slice2_pkg;

  typedef enum logic [2:0] {
    OP_ADD    = 3'd0,
    OP_SUB    = 3'd1,
    OP_ADDSUB = 3'd2,
    OP_UP     = 3'd3,
    OP_DOWN   = 3'd4,
    OP_UPDN   = 3'd5,
    OP_CMP    = 3'd6,
    OP_SPARE  = 3'd7
  } slice_op_e;

  function automatic logic op_counts(slice_op_e o);
    return (o == OP_UP) || (o == OP_DOWN) || (o == OP_UPDN);
  endfunction

  function automatic logic op_inverts(slice_op_e o, logic sel);
    return (o == OP_SUB) || (o == OP_CMP) || ((o == OP_ADDSUB) && sel);
  endfunction

endpackage

// File: rtl/arith_slice2_adder.sv
module arith_slice2_adder #(
  parameter int W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] bx,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         grp_g,
  output logic         grp_p
);

  logic [W:0] carry;
  assign carry[0] = cin;

  // Bit-level ripple path
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign sum[i]     = a[i] ^ bx[i] ^ carry[i];
      assign carry[i+1] = (a[i] & bx[i]) | ((a[i] ^ bx[i]) & carry[i]);
    end
  endgenerate

  assign cout = carry[W];

  // Group terms folded from the LSB upward, independent of the ripple path
  always_comb begin
    grp_g = 1'b0;
    grp_p = 1'b1;
    for (int i = 0; i < W; i++) begin
      grp_g = (a[i] & bx[i]) | ((a[i] ^ bx[i]) & grp_g);
      grp_p = grp_p & (a[i] ^ bx[i]);
    end
  end

endmodule

// File: rtl/arith_slice2_counter.sv
module arith_slice2_counter #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         aclr,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] STEP = {{(W-1){1'b0}}, 1'b1};

  // Priority: clear, then preload, then step
  always_ff @(posedge clk or posedge aclr) begin
    if (aclr)      q <= '0;
    else if (load) q <= d;
    else if (inc)  q <= q + STEP;
    else if (dec)  q <= q - STEP;
  end

  assert_clear_R10: assert property (@(posedge clk) aclr |-> (q == '0))
    else $error("counter not cleared under aclr");

  assert_load_R9: assert property (@(posedge clk) disable iff (aclr)
    load |=> (q == $past(d)))
    else $error("preload not taken");

  assert_hold_R8: assert property (@(posedge clk) disable iff (aclr)
    (!load && !inc && !dec) |=> (q == $past(q)))
    else $error("counter moved while idle");

  assert_step_up_R5: assert property (@(posedge clk) disable iff (aclr)
    (!load && inc) |=> (q == $past(q) + STEP))
    else $error("up step wrong");

  assert_step_dn_R6: assert property (@(posedge clk) disable iff (aclr)
    (!load && !inc && dec) |=> (q == $past(q) - STEP))
    else $error("down step wrong");

endmodule

// File: rtl/arith_slice2_cmp.sv
module arith_slice2_cmp #(
  parameter int W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         ge,
  output logic         ne,
  output logic         le
);

  always_comb begin
    ge = (a >= b);
    le = (a <= b);
    ne = (a != b);
  end

endmodule

// File: rtl/arith_slice2.sv
module arith_slice2
  import arith_slice2_pkg::*;
#(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         aclr,
  input  logic [2:0]   op,
  input  logic         sub_sel,
  input  logic         dir_up,
  input  logic         load,
  input  logic         cin,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         grp_g,
  output logic         grp_p,
  output logic         ge,
  output logic         ne,
  output logic         le
);

  slice_op_e    op_e;
  logic         invert_b;
  logic         count_mode;
  logic         count_up;
  logic         inc;
  logic         dec;
  logic [W-1:0] bx;
  logic [W-1:0] sum;
  logic         add_cout;
  logic         add_g;
  logic         add_p;
  logic [W-1:0] q;
  logic         cnt_cout;

  always_comb begin
    op_e       = slice_op_e'(op);
    invert_b   = op_inverts(op_e, sub_sel);
    count_mode = op_counts(op_e);
    count_up   = (op_e == OP_UP) || ((op_e == OP_UPDN) && dir_up);
    inc        = count_mode && cin && count_up;
    dec        = count_mode && cin && !count_up;
    bx         = invert_b ? ~b : b;
  end

  arith_slice2_adder #(.W(W)) u_adder (
    .a     (a),
    .bx    (bx),
    .cin   (cin),
    .sum   (sum),
    .cout  (add_cout),
    .grp_g (add_g),
    .grp_p (add_p)
  );

  arith_slice2_counter #(.W(W)) u_counter (
    .clk  (clk),
    .aclr (aclr),
    .load (load),
    .d    (a),
    .inc  (inc),
    .dec  (dec),
    .q    (q)
  );

  arith_slice2_cmp #(.W(W)) u_cmp (
    .a  (a),
    .b  (b),
    .ge (ge),
    .ne (ne),
    .le (le)
  );

  always_comb begin
    cnt_cout = count_up ? (cin && (&q)) : (cin && !(|q));
    res      = count_mode ? q : sum;
    cout     = count_mode ? cnt_cout : add_cout;
    grp_g    = count_mode ? 1'b0 : add_g;
    grp_p    = count_mode ? 1'b0 : add_p;
  end

  assert_cout_gp_R4: assert property (@(posedge clk) disable iff (aclr)
    !count_mode |-> (cout == (grp_g | (grp_p & cin))))
    else $error("carry out disagrees with group terms");

  assert_cmp_flags_R11: assert property (@(posedge clk) disable iff (aclr)
    (ge || le) && (ne == !(ge && le)))
    else $error("comparator flags inconsistent");

endmodule

// File: tb/arith_slice2_bench.sv
module arith_slice2_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 2;
  localparam int M = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         aclr, sub_sel, dir_up, load, cin;
  logic [2:0]   op;
  logic [W-1:0] a, b;
  logic [W-1:0] res;
  logic         cout, grp_g, grp_p, ge, ne, le;

  int n_checks = 0;
  int n_fail   = 0;
  int qm       = 0;
  string q_tag = "R10";
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  arith_slice2 u_arith_slice2 (
    .clk(clk), .aclr(aclr), .op(op), .sub_sel(sub_sel), .dir_up(dir_up),
    .load(load), .cin(cin), .a(a), .b(b), .res(res), .cout(cout),
    .grp_g(grp_g), .grp_p(grp_p), .ge(ge), .ne(ne), .le(le)
  );

  task automatic check(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d (op=%0d a=%0d b=%0d cin=%0d)",
               tag, what, act, exp, op, a, b, cin);
    end
  endtask

  function automatic string arith_tag(int o);
    case (o)
      1: return "R2";
      2: return "R3";
      6: return "R12";
      default: return "R1";
    endcase
  endfunction

  function automatic string cnt_tag(int o);
    case (o)
      3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic compare_all();
    int  o   = int'(op);
    bit  cnt = (o >= 3) && (o <= 5);
    bit  up  = (o == 3) || ((o == 5) && dir_up);
    bit  inv = (o == 1) || (o == 6) || ((o == 2) && sub_sel);
    int  x   = inv ? ((~int'(b)) & M) : int'(b);
    int  s   = int'(a) + x + int'(cin);
    int  gg  = 0;
    int  pp  = 1;
    for (int i = 0; i < W; i++) begin
      int ai = (int'(a) >> i) & 1;
      int xi = (x >> i) & 1;
      gg = (ai & xi) | ((ai ^ xi) & gg);
      pp = pp & (ai ^ xi);
    end
    if (cnt) begin
      check(q_tag, "res(counter)", int'(res), qm);
      check(cnt_tag(o), "cout(counter)", int'(cout),
            (cin && (up ? (qm == M) : (qm == 0))) ? 1 : 0);
      check("R4", "grp_g(counter)", int'(grp_g), 0);
      check("R4", "grp_p(counter)", int'(grp_p), 0);
    end else begin
      check(arith_tag(o), "res", int'(res), s & M);
      check(arith_tag(o), "cout", int'(cout), (s >> W) & 1);
      check("R4", "grp_g", int'(grp_g), gg);
      check("R4", "grp_p", int'(grp_p), pp);
    end
    check("R11", "ge", int'(ge), (a >= b) ? 1 : 0);
    check("R11", "le", int'(le), (a <= b) ? 1 : 0);
    check("R11", "ne", int'(ne), (a != b) ? 1 : 0);
  endtask

  // Drive on the falling edge, sample 1 ns later, update the model after the rising edge
  task automatic apply(int o, int va, int vb, bit c, bit ld, bit ss, bit du);
    @(negedge clk);
    op = 3'(o); a = W'(va); b = W'(vb); cin = c; load = ld; sub_sel = ss; dir_up = du;
    #1;
    compare_all();
    @(posedge clk);
    begin
      bit cnt = (o >= 3) && (o <= 5);
      bit up  = (o == 3) || ((o == 5) && du);
      if (ld) begin
        qm = va & M; q_tag = "R9";
      end else if (cnt && c) begin
        qm = up ? ((qm + 1) & M) : ((qm - 1) & M);
        q_tag = cnt_tag(o);
      end else begin
        q_tag = "R8";
      end
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    op = 3'd3; load = 1'b1; a = W'(M); cin = 1'b1;
    #1;
    aclr = 1'b1;
    #1;
    check("R10", "res right after aclr", int'(res), 0);
    @(posedge clk);
    #1;
    check("R10", "res with aclr and load", int'(res), 0);
    @(negedge clk);
    aclr = 1'b0; load = 1'b0; cin = 1'b0;
    qm = 0; q_tag = "R10";
  endtask

  initial begin
    int limit = 150000;
    repeat (limit) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    aclr = 1'b1; op = 3'd3; a = '0; b = '0; cin = 1'b0; load = 1'b0;
    sub_sel = 1'b0; dir_up = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R10", "reset state res", int'(res), 0);
    @(negedge clk);
    aclr = 1'b0;

    // Directed: every operand pair in each arithmetic mode, both carry-ins
    for (int o = 0; o < 8; o++) begin
      if (o >= 3 && o <= 5) continue;
      for (int va = 0; va <= M; va++)
        for (int vb = 0; vb <= M; vb++)
          for (int c = 0; c < 2; c++)
            for (int ss = 0; ss < 2; ss++)
              apply(o, va, vb, c[0], 1'b0, ss[0], 1'b0);
    end

    // Up count through wrap, then down, then up/down both ways
    apply(3, 2, 0, 1'b1, 1'b1, 1'b0, 1'b0);
    repeat (6) apply(3, 0, 1, 1'b1, 1'b0, 1'b0, 1'b0);
    repeat (6) apply(4, 1, 2, 1'b1, 1'b0, 1'b0, 1'b0);
    repeat (5) apply(5, 3, 3, 1'b1, 1'b0, 1'b0, 1'b1);
    repeat (5) apply(5, 0, 2, 1'b1, 1'b0, 1'b0, 1'b0);
    // Hold: count disabled, and a non-counting mode
    repeat (3) apply(3, 1, 1, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) apply(0, 2, 1, 1'b1, 1'b0, 1'b0, 1'b0);
    // Preload in a non-counting mode, then observe
    apply(1, 1, 0, 1'b1, 1'b1, 1'b0, 1'b0);
    apply(3, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    pulse_clear();
    apply(4, 0, 0, 1'b1, 1'b0, 1'b0, 1'b0);
    apply(4, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0);

    // Mixed stimulus
    for (int k = 0; k < 3000; k++) begin
      if (k % 500 == 250) pulse_clear();
      apply($urandom_range(0, 7), $urandom_range(0, M), $urandom_range(0, M),
            1'($urandom_range(0, 1)), ($urandom_range(0, 9) == 0),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule